// File: doc/BRIEF.md
# Byte-Wide Host to Word-Wide Data Port Bridge

This bridge sits between a host bus that moves one byte per access and a device whose data register is sixteen bits wide. It adds a one-byte holding register (the latch) at its own host address. A host read of the data address fetches a whole word from the device, hands the host its low byte, and parks the high byte in the latch, where a following latch read picks it up. For a write, the host first loads the high byte into the latch. Its byte written to the data address then goes out together with the latch as one word.

Every other host address goes through unchanged as a byte access. The device sees the low byte of its write bus and returns its byte in the low byte of its read bus. The bridge finds the rising edge of the host strobe and issues one device access per host access, however long the host holds its strobe. Read results come back on a registered byte port with a one-cycle valid pulse. A parameter selects whether the two bytes of a word are exchanged between host order and device order.

Top module: `byte_latch_bridge`

## Requirements
- R1: After reset the latch holds 0x00, `host_rvalid` and `dev_stb` are low and `host_rdata` is 0x00.
- R2: A host read of the data address (0x0) makes exactly one device access with `dev_we`=0, `dev_wide`=1 and `dev_addr`=0x0, in the cycle of the strobe edge.
- R3: A host read of the latch address (0x8) makes no device access and returns the latch contents.
- R4: A host write to the latch address (0x8) makes no device access and changes only the latch.
- R5: A host write to the data address makes exactly one device access with `dev_we`=1 and `dev_wide`=1. The word carries the written byte as its host-order low half and the latch as its host-order high half.
- R6: A host access to any other address is passed on with `dev_wide`=0 and the same address. A write drives `dev_wdata` = {0x00, byte}, a read returns `dev_rdata[7:0]`, and the latch is left unchanged.
- R7: With byte exchange enabled (default), the host-order word is {dev[7:0], dev[15:8]}. A data read therefore returns `dev_rdata[15:8]` and stores `dev_rdata[7:0]` in the latch, and a data write drives `dev_wdata` = {byte, latch}.
- R8: A host strobe held high for several cycles produces one device strobe, in its first cycle. A new access needs the strobe to be low for at least one cycle first.
- R9: `host_rvalid` pulses for one cycle, one cycle after the strobe edge of each host read, and never after a write. `host_rdata` holds the result from then until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_stb | input | 1 | Host access request, level; its rising edge starts one access |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read result |
| host_rvalid | output | 1 | One-cycle pulse marking a new read result |
| dev_stb | output | 1 | Single-cycle device access strobe |
| dev_we | output | 1 | Device access direction, 1 = write |
| dev_wide | output | 1 | 1 = sixteen-bit data register access |
| dev_addr | output | ADDR_W | Device register address |
| dev_wdata | output | 16 | Device write word |
| dev_rdata | input | 16 | Device read word, valid in the cycle of `dev_stb` |

## Verification
The device strobe and its address, direction, width and write word are combinational. They are due in the same cycle as the host strobe edge, so the reference model predicts them from the inputs of that cycle together with its own record of the previous strobe level. Read data, the valid pulse and the latch are registered and are due one cycle after the edge. The model updates them at the clock edge and compares them in the following half cycle. Inputs change just after the rising edge and every comparison is made on the falling edge, so each expected value is sampled in the cycle it is due.

// File: rtl/lpb_pkg.sv
package lpb_pkg;

  typedef enum logic [1:0] {
    ACC_PLAIN = 2'd0,
    ACC_DATA  = 2'd1,
    ACC_LATCH = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/lpb_strobe_edge.sv
module lpb_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  output logic start_o
);

  logic stb_q;
  logic stb_d;

  always_comb begin
    stb_d   = stb_i;
    start_o = stb_i & ~stb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_d;
  end

  // R8: an access start is never followed by another in the next cycle
  a_r8_one_start_per_strobe: assert property (
    @(posedge clk) disable iff (!rst_n) start_o |=> !start_o);

endmodule

// File: rtl/lpb_decode.sv
module lpb_decode #(
  parameter int unsigned ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h0,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 'h8
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output lpb_pkg::acc_kind_e kind_o
);

  always_comb begin
    if (addr_i == LATCH_ADDR)     kind_o = lpb_pkg::ACC_LATCH;
    else if (addr_i == DATA_ADDR) kind_o = lpb_pkg::ACC_DATA;
    else                          kind_o = lpb_pkg::ACC_PLAIN;
  end

endmodule

// File: rtl/lpb_order.sv
module lpb_order #(
  parameter int unsigned BYTE_W = 8,
  parameter bit          SWAP   = 1'b1,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);

  generate
    if (SWAP) begin : g_exchange
      assign word_o = {word_i[BYTE_W-1:0], word_i[WORD_W-1:BYTE_W]};
    end else begin : g_straight
      assign word_o = word_i;
    end
  endgenerate

endmodule

// File: rtl/byte_latch_bridge.sv
module byte_latch_bridge #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned BYTE_W     = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h0,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 'h8,
  parameter bit          SWAP_BYTES = 1'b1,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_stb,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              dev_stb,
  output logic              dev_we,
  output logic              dev_wide,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [WORD_W-1:0] dev_wdata,
  input  logic [WORD_W-1:0] dev_rdata
);

  import lpb_pkg::*;

  logic              start;
  acc_kind_e         kind;
  logic [BYTE_W-1:0] latch_q, latch_d;
  logic              latch_en;
  logic [BYTE_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;
  logic              rvalid_q, rvalid_d;
  logic [WORD_W-1:0] rd_host_word;
  logic [WORD_W-1:0] wr_host_word;
  logic [WORD_W-1:0] wr_dev_word;

  lpb_strobe_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb_i   (host_stb),
    .start_o (start)
  );

  lpb_decode #(
    .ADDR_W     (ADDR_W),
    .DATA_ADDR  (DATA_ADDR),
    .LATCH_ADDR (LATCH_ADDR)
  ) u_decode (
    .addr_i (host_addr),
    .kind_o (kind)
  );

  lpb_order #(.BYTE_W(BYTE_W), .SWAP(SWAP_BYTES)) u_rd_order (
    .word_i (dev_rdata),
    .word_o (rd_host_word)
  );

  assign wr_host_word = {latch_q, host_wdata};

  lpb_order #(.BYTE_W(BYTE_W), .SWAP(SWAP_BYTES)) u_wr_order (
    .word_i (wr_host_word),
    .word_o (wr_dev_word)
  );

  // device side, combinational in the cycle of the strobe edge
  always_comb begin
    dev_stb   = start && (kind != ACC_LATCH);
    dev_we    = host_we;
    dev_wide  = (kind == ACC_DATA);
    dev_addr  = host_addr;
    dev_wdata = (kind == ACC_DATA) ? wr_dev_word
                                   : {{BYTE_W{1'b0}}, host_wdata};
  end

  // next state
  always_comb begin
    latch_en = start && (((kind == ACC_LATCH) && host_we) ||
                         ((kind == ACC_DATA) && !host_we));
    latch_d  = (kind == ACC_LATCH) ? host_wdata
                                   : rd_host_word[WORD_W-1:BYTE_W];
    rdata_en = start && !host_we;
    unique case (kind)
      ACC_LATCH: rdata_d = latch_q;
      ACC_DATA:  rdata_d = rd_host_word[BYTE_W-1:0];
      default:   rdata_d = dev_rdata[BYTE_W-1:0];
    endcase
    rvalid_d = start && !host_we;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      if (latch_en) latch_q <= latch_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;

  // R3 / R4: latch accesses stay inside the bridge
  a_r3_latch_no_device: assert property (
    @(posedge clk) disable iff (!rst_n)
    (start && (host_addr == LATCH_ADDR)) |-> !dev_stb);

  // R4 / R6: with no access started the latch keeps its value
  a_r4_latch_idle_stable: assert property (
    @(posedge clk) disable iff (!rst_n) !start |=> $stable(latch_q));

  // R9: every read start yields a valid pulse one cycle later
  a_r9_rvalid_after_read: assert property (
    @(posedge clk) disable iff (!rst_n)
    (start && !host_we) |=> host_rvalid);

  // R9: a valid pulse only follows a read start
  a_r9_rvalid_only_reads: assert property (
    @(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(start && !host_we));

  // R2 / R5: a device strobe for the data address is always wide
  a_r2_data_is_wide: assert property (
    @(posedge clk) disable iff (!rst_n)
    (dev_stb && (dev_addr == DATA_ADDR)) |-> dev_wide);

endmodule

// File: tb/byte_latch_bridge_bench.sv
module byte_latch_bridge_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [3:0] A_DATA  = 4'h0;
  localparam logic [3:0] A_LATCH = 4'h8;

  logic        clk;
  logic        rst_n;
  logic        host_stb;
  logic        host_we;
  logic [3:0]  host_addr;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic        dev_stb;
  logic        dev_we;
  logic        dev_wide;
  logic [3:0]  dev_addr;
  logic [15:0] dev_wdata;
  logic [15:0] dev_rdata;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // reference model state
  logic [7:0] m_latch;
  logic       m_stbq;
  logic       m_rv;
  logic [7:0] m_rd;
  string      m_rtag;

  byte_latch_bridge u_byte_latch_bridge (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_stb    (host_stb),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .dev_stb     (dev_stb),
    .dev_we      (dev_we),
    .dev_wide    (dev_wide),
    .dev_addr    (dev_addr),
    .dev_wdata   (dev_wdata),
    .dev_rdata   (dev_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      fails++;
      $display("FAIL R8 watchdog: actual %0d cycles expected < %0d",
               cycles, WATCHDOG);
      finish_run();
    end
  end

  // behavioural model, state updated on the rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_latch = 8'h00; m_stbq = 0; m_rv = 0; m_rd = 8'h00; m_rtag = "R1";
    end else begin
      bit st;
      st   = host_stb && !m_stbq;
      m_rv = st && !host_we;
      if (st) begin
        if (host_addr == A_LATCH) begin
          if (host_we) m_latch = host_wdata;
          else begin m_rd = m_latch; m_rtag = "R3"; end
        end else if (host_addr == A_DATA) begin
          if (!host_we) begin          // R7: host low = dev[15:8]
            m_rd    = dev_rdata[15:8];
            m_latch = dev_rdata[7:0];
            m_rtag  = "R2/R7";
          end
        end else if (!host_we) begin
          m_rd = dev_rdata[7:0]; m_rtag = "R6";
        end
      end
      m_stbq = host_stb;
    end
  end

  // comparison on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit st, exp_stb;
      string tag;
      st      = host_stb && !m_stbq;
      exp_stb = st && (host_addr != A_LATCH);
      if (host_stb && m_stbq)        tag = "R8";
      else if (host_addr == A_LATCH) tag = host_we ? "R4" : "R3";
      else if (host_addr == A_DATA)  tag = host_we ? "R5" : "R2";
      else                           tag = "R6";
      chk({tag, " dev_stb"}, {15'd0, dev_stb}, {15'd0, exp_stb});
      if (exp_stb) begin
        chk({tag, " dev_we"},   {15'd0, dev_we},   {15'd0, host_we});
        chk({tag, " dev_wide"}, {15'd0, dev_wide},
            {15'd0, host_addr == A_DATA});
        chk({tag, " dev_addr"}, {12'd0, dev_addr}, {12'd0, host_addr});
        if (host_we) begin
          if (host_addr == A_DATA)     // R7: device word {byte, latch}
            chk("R5/R7 dev_wdata", dev_wdata, {host_wdata, m_latch});
          else
            chk("R6 dev_wdata", dev_wdata, {8'h00, host_wdata});
        end
      end
      chk("R9 host_rvalid", {15'd0, host_rvalid}, {15'd0, m_rv});
      if (m_rv) chk({m_rtag, " host_rdata"}, {8'd0, host_rdata}, {8'd0, m_rd});
    end
  end

  // one host access: strobe held for hold cycles, then one low cycle
  task automatic access(input bit we, input logic [3:0] addr,
                        input logic [7:0] wd, input logic [15:0] rd,
                        input int hold);
    @(posedge clk); #1;
    host_stb = 1; host_we = we; host_addr = addr; host_wdata = wd;
    dev_rdata = rd;
    for (int i = 0; i < hold; i++) @(posedge clk);
    #1 host_stb = 0;
  endtask

  task automatic read_now(input logic [3:0] addr, input logic [15:0] rd,
                          output logic [7:0] val);
    access(0, addr, 8'h00, rd, 1);
    @(negedge clk);
    val = host_rdata;
  endtask

  initial begin
    logic [7:0]  v;
    logic [15:0] lfsr;
    rst_n = 0; host_stb = 0; host_we = 0; host_addr = '0;
    host_wdata = '0; dev_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 dev_stb", {15'd0, dev_stb}, 16'd0);
    chk("R1 host_rvalid", {15'd0, host_rvalid}, 16'd0);
    chk("R1 host_rdata", {8'd0, host_rdata}, 16'd0);
    #1 rst_n = 1;

    read_now(A_LATCH, 16'hFFFF, v);
    chk("R1 latch after reset", {8'd0, v}, 16'h0000);

    read_now(A_DATA, 16'hA55A, v);
    chk("R2 data read low byte", {8'd0, v}, 16'h00A5);
    read_now(A_LATCH, 16'h0000, v);
    chk("R7 latch holds dev low", {8'd0, v}, 16'h005A);

    access(1, A_LATCH, 8'h3C, 16'h0000, 1);
    read_now(A_LATCH, 16'h0000, v);
    chk("R4 latch write", {8'd0, v}, 16'h003C);
    access(1, A_DATA, 8'h81, 16'h0000, 1);

    access(1, 4'h3, 8'h77, 16'h0000, 1);
    read_now(4'h5, 16'h12F0, v);
    chk("R6 plain read", {8'd0, v}, 16'h00F0);
    read_now(A_LATCH, 16'hEEEE, v);
    chk("R6 latch untouched", {8'd0, v}, 16'h003C);

    access(0, A_DATA, 8'h00, 16'hC381, 4);   // R8 long strobe
    access(1, A_DATA, 8'h19, 16'h0000, 3);
    access(1, A_LATCH, 8'hE7, 16'h0000, 2);
    read_now(A_LATCH, 16'h0000, v);
    chk("R8 latch after held read", {8'd0, v}, 16'h00E7);

    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      logic [3:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: a = A_DATA;
        2'd1: a = A_LATCH;
        2'd2: a = 4'h3;
        default: a = lfsr[7:4];
      endcase
      access(lfsr[2], a, lfsr[15:8], {lfsr[7:0], lfsr[15:8]},
             1 + int'(lfsr[4:3]));
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule